// File: doc/BRIEF.md
# SPI Register-Bridge Transaction Master

This block carries 32-bit register reads and writes to a remote device that sits behind a serial link. A request gives the direction, a 32-bit address, a byte count and, for writes, the data. The block turns the request into a short series of SPI mode-3 frames. The first frame loads the remote configuration register with the address and the transfer size, and for writes it also carries the data. The block then reads the remote status register until the access completes, fails, or runs out of retries. For a read, a last frame fetches four bytes from the remote data register.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an access is in flight, `req_ready` stays low, so a request held on the inputs simply waits. The block has no back-pressure on the response side. It produces a one-cycle `done` pulse. With that pulse, `error` and `rdata` are valid, and both hold their values until the next request is taken.

Command codes, register addresses, field positions, the retry limit and the half-period of the serial clock are all parameters.

Top module: `spi_regbridge_master`

## Requirements
- R1: After reset, and whenever `busy` is low, the link idles with `spi_cs_n`=1, `spi_sck`=1 and `spi_mosi`=0.
- R2: The serial clock is high whenever chip select is high. Each bit is placed on `spi_mosi` while `spi_sck` is low and is stable across the rising edge that the device samples. Bytes are sent most significant bit first.
- R3: A write is one 11-byte frame made of: write command 0x02, config address 0x10, config byte, address bytes from most to least significant, then data bytes from most to least significant. The config byte holds (4 − length) in bits [3:1] and 0 in bit 0.
- R4: For a write of length L, the data sent is `req_wdata` shifted left by 8×(4 − L) bits, so the valid bytes lead.
- R5: A read first sends a 7-byte frame: 0x02, 0x10, a config byte with (4 − length) in bits [3:1] and the read trigger in bit 0 set to 1, then the four address bytes with the most significant byte first.
- R6: After the first frame, each poll is a 3-byte frame: read command 0x03, status address 0x14, then one byte clocked in. A status byte with busy (bit 4) clear and fail (bit 3) clear completes the access without error.
- R7: A status byte with the fail bit (bit 3) set ends the access with `error`=1. No further frames follow.
- R8: If the busy bit is still set after 4 status reads, the access ends with `error`=1 and no further frames follow.
- R9: After a good read poll, a 6-byte frame is sent: 0x03, data address 0x20, then four bytes clocked in. These bytes form `rdata` with the first byte as the most significant.
- R10: A request with length greater than 4 gets `done` with `error`=1 on the cycle after acceptance, and chip select never goes low.
- R11: While bytes are being clocked in, `spi_mosi` is held low.
- R12: `req_ready` equals not `busy`. `busy` rises on the cycle after acceptance and stays high through the single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Remote register address |
| req_len | input | 3 | Byte count, 1 to 4 |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Access failed; valid with done |
| rdata | output | 32 | Read result; valid with done |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The hardest paths to reach are the ones that depend on what the remote device answers. These are polls that stay busy until the retry limit runs out, and a fail bit that arrives after several busy replies. Neither can be driven from the request port alone.

The bench therefore contains a device model that decodes each frame from the serial lines. It answers status reads from a scripted queue of status bytes, with a fallback value once the queue is empty. This lets each test set the exact poll count and outcome. The model also captures every frame byte by byte, so both framing and MOSI-low during read-back are compared against the expected frames.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    FR_CFG   = 2'd0,
    FR_POLL  = 2'd1,
    FR_FETCH = 2'd2
  } frame_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_GAP   = 3'd4,
    ST_RESP  = 3'd5
  } state_t;
endpackage

// File: rtl/srb_frame_builder.sv
module srb_frame_builder
  import srb_pkg::*;
#(
  parameter logic [7:0] CMD_WRITE     = 8'h02,
  parameter logic [7:0] CMD_READ      = 8'h03,
  parameter logic [7:0] CFG_ADDR      = 8'h10,
  parameter logic [7:0] STATUS_ADDR   = 8'h14,
  parameter logic [7:0] DATA0_ADDR    = 8'h20,
  parameter int         MODE_LSB      = 1,
  parameter int         READ_TRIG_BIT = 0
) (
  input  frame_t      kind,
  input  logic [3:0]  idx,
  input  logic        is_write,
  input  logic [2:0]  len,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [7:0]  tx_byte,
  output logic [3:0]  last_idx,
  output logic        rx_slot
);
  logic [7:0] cfg_byte;
  logic [3:0] addr_sel;
  logic [3:0] data_sel;

  always_comb begin
    cfg_byte = '0;
    cfg_byte[MODE_LSB +: 3] = 3'd4 - len;
    if (!is_write) cfg_byte[READ_TRIG_BIT] = 1'b1;
  end

  assign addr_sel = 4'd6 - idx;
  assign data_sel = 4'd10 - idx;

  always_comb begin
    tx_byte  = 8'h00;
    last_idx = 4'd0;
    rx_slot  = 1'b0;
    unique case (kind)
      FR_CFG: begin
        last_idx = is_write ? 4'd10 : 4'd6;
        if (idx == 4'd0)      tx_byte = CMD_WRITE;
        else if (idx == 4'd1) tx_byte = CFG_ADDR;
        else if (idx == 4'd2) tx_byte = cfg_byte;
        else if (idx <= 4'd6) tx_byte = 8'(addr >> {addr_sel[1:0], 3'b000});
        else                  tx_byte = 8'(wdata >> {data_sel[1:0], 3'b000});
      end
      FR_POLL: begin
        last_idx = 4'd2;
        rx_slot  = (idx >= 4'd2);
        if (idx == 4'd0)      tx_byte = CMD_READ;
        else if (idx == 4'd1) tx_byte = STATUS_ADDR;
      end
      FR_FETCH: begin
        last_idx = 4'd5;
        rx_slot  = (idx >= 4'd2);
        if (idx == 4'd0)      tx_byte = CMD_READ;
        else if (idx == 4'd1) tx_byte = DATA0_ADDR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/srb_byte_shifter.sv
module srb_byte_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active_q;
  logic          phase_hi_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    tx_sh_q;
  logic [7:0]    rx_sh_q;

  assign rx_byte = rx_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      phase_hi_q <= 1'b1;
      bit_q      <= '0;
      cnt_q      <= '0;
      tx_sh_q    <= '0;
      rx_sh_q    <= '0;
      sck        <= 1'b1;
      mosi       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q   <= 1'b1;
          phase_hi_q <= 1'b0;
          bit_q      <= '0;
          cnt_q      <= '0;
          sck        <= 1'b0;
          mosi       <= tx_byte[7];
          tx_sh_q    <= {tx_byte[6:0], 1'b0};
        end
      end else if (cnt_q == CW'(HALF - 1)) begin
        cnt_q <= '0;
        if (!phase_hi_q) begin
          rx_sh_q    <= {rx_sh_q[6:0], miso};
          sck        <= 1'b1;
          phase_hi_q <= 1'b1;
        end else if (bit_q == 3'd7) begin
          active_q <= 1'b0;
          done     <= 1'b1;
          mosi     <= 1'b0;
        end else begin
          bit_q      <= bit_q + 3'd1;
          sck        <= 1'b0;
          phase_hi_q <= 1'b0;
          mosi       <= tx_sh_q[7];
          tx_sh_q    <= {tx_sh_q[6:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R2: data stays put through the whole high phase of a bit
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && phase_hi_q && $past(active_q && phase_hi_q)) |-> $stable(mosi));

  // R2: the clock only falls while a byte is in progress
  a_r2_sck_falls_active: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> active_q);
endmodule

// File: rtl/spi_regbridge_master.sv
module spi_regbridge_master
  import srb_pkg::*;
#(
  parameter int         HALF          = 2,
  parameter int         RETRY_MAX     = 4,
  parameter logic [7:0] CMD_WRITE     = 8'h02,
  parameter logic [7:0] CMD_READ      = 8'h03,
  parameter logic [7:0] CFG_ADDR      = 8'h10,
  parameter logic [7:0] STATUS_ADDR   = 8'h14,
  parameter logic [7:0] DATA0_ADDR    = 8'h20,
  parameter int         MODE_LSB      = 1,
  parameter int         READ_TRIG_BIT = 0,
  parameter int         BUSY_BIT      = 4,
  parameter int         FAIL_BIT      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [2:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [31:0] rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int GAP_CYC = 2 * HALF;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int RW      = $clog2(RETRY_MAX + 1);

  state_t        st_q;
  frame_t        fr_q;
  logic [3:0]    idx_q;
  logic          wr_q;
  logic [2:0]    len_q;
  logic [31:0]   addr_q;
  logic [31:0]   wdata_q;
  logic [31:0]   acc_q;
  logic [31:0]   rdata_q;
  logic          err_q;
  logic          cs_n_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] polls_q;

  logic       eng_start;
  logic       eng_done;
  logic [7:0] eng_rx;
  logic [7:0] tx_byte;
  logic [3:0] last_idx;
  logic       rx_slot;
  logic       accept;

  assign accept    = req_valid && (st_q == ST_IDLE);
  assign eng_start = (st_q == ST_START);
  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_RESP);
  assign error     = err_q;
  assign rdata     = rdata_q;
  assign spi_cs_n  = cs_n_q;

  srb_frame_builder #(
    .CMD_WRITE(CMD_WRITE), .CMD_READ(CMD_READ), .CFG_ADDR(CFG_ADDR),
    .STATUS_ADDR(STATUS_ADDR), .DATA0_ADDR(DATA0_ADDR),
    .MODE_LSB(MODE_LSB), .READ_TRIG_BIT(READ_TRIG_BIT)
  ) builder_i (
    .kind(fr_q), .idx(idx_q), .is_write(wr_q), .len(len_q),
    .addr(addr_q), .wdata(wdata_q),
    .tx_byte(tx_byte), .last_idx(last_idx), .rx_slot(rx_slot)
  );

  srb_byte_shifter #(.HALF(HALF)) shifter_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_byte),
    .done(eng_done), .rx_byte(eng_rx),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fr_q    <= FR_CFG;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      gap_q   <= '0;
      polls_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          len_q   <= req_len;
          addr_q  <= req_addr;
          wdata_q <= req_wdata << {(3'd4 - req_len), 3'b000};
          rdata_q <= '0;
          polls_q <= '0;
          fr_q    <= FR_CFG;
          idx_q   <= '0;
          if (req_len > 3'd4) begin
            err_q <= 1'b1;
            st_q  <= ST_RESP;
          end else begin
            err_q  <= 1'b0;
            cs_n_q <= 1'b0;
            st_q   <= ST_START;
          end
        end
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (rx_slot) acc_q <= {acc_q[23:0], eng_rx};
          if (idx_q == last_idx) begin
            cs_n_q <= 1'b1;
            st_q   <= ST_EVAL;
          end else begin
            idx_q <= idx_q + 4'd1;
            st_q  <= ST_START;
          end
        end
        ST_EVAL: begin
          gap_q <= '0;
          unique case (fr_q)
            FR_CFG: begin
              fr_q <= FR_POLL;
              st_q <= ST_GAP;
            end
            FR_POLL: begin
              polls_q <= polls_q + RW'(1);
              if (acc_q[FAIL_BIT]) begin
                err_q <= 1'b1;
                st_q  <= ST_RESP;
              end else if (!acc_q[BUSY_BIT]) begin
                if (wr_q) st_q <= ST_RESP;
                else begin
                  fr_q <= FR_FETCH;
                  st_q <= ST_GAP;
                end
              end else if (polls_q == RW'(RETRY_MAX - 1)) begin
                err_q <= 1'b1;
                st_q  <= ST_RESP;
              end else begin
                st_q <= ST_GAP;
              end
            end
            default: begin
              rdata_q <= acc_q;
              st_q    <= ST_RESP;
            end
          endcase
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            cs_n_q <= 1'b0;
            idx_q  <= '0;
            st_q   <= ST_START;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: idle link levels whenever no access is running
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && spi_sck && !spi_mosi));

  // R2: clock is high while deselected
  a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sck);

  // R8: never more status reads than the retry limit
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= RW'(RETRY_MAX));

  // R10: oversize length rejected at once without selecting the device
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len > 3'd4)) |=> (done && error && spi_cs_n));

  // R12: done is a single-cycle pulse inside the busy window
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/spi_regbridge_master_tb.sv
module spi_regbridge_master_tb_top;
  localparam logic [7:0] C_WR  = 8'h02;
  localparam logic [7:0] C_RD  = 8'h03;
  localparam logic [7:0] A_CFG = 8'h10;
  localparam logic [7:0] A_ST  = 8'h14;
  localparam logic [7:0] A_D0  = 8'h20;
  localparam int         RMAX  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, error;
  logic [31:0] rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spi_regbridge_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .busy(busy), .done(done), .error(error),
    .rdata(rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- remote device model ----------------
  logic [7:0] cap_bytes[$];
  int         cap_lens[$];
  logic [7:0] status_q[$];
  logic [7:0] status_default = 8'h00;
  logic [31:0] dev_word = '0;
  int   nbits = 0;
  int   curlen = 0;
  bit   in_frame = 0;
  bit   rd_frame = 0;
  logic [7:0] shreg = '0;
  logic [7:0] resp [4];
  int   cs_falls = 0;

  always @(negedge spi_cs_n) begin
    nbits = 0; curlen = 0; rd_frame = 0; in_frame = 1; cs_falls++;
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) cap_lens.push_back(curlen);
    in_frame = 0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if (rd_frame && nbits >= 16) chk(spi_mosi == 1'b0, "R11 mosi during read-back", 32'(spi_mosi), 0);
      shreg = {shreg[6:0], spi_mosi};
      nbits++;
      if (nbits % 8 == 0) begin
        cap_bytes.push_back(shreg);
        curlen++;
        if (nbits == 8) rd_frame = (shreg == C_RD);
        if (nbits == 16 && rd_frame) begin
          if (shreg == A_ST) begin
            resp[0] = (status_q.size() > 0) ? status_q.pop_front() : status_default;
          end else begin
            resp[0] = dev_word[31:24]; resp[1] = dev_word[23:16];
            resp[2] = dev_word[15:8];  resp[3] = dev_word[7:0];
          end
        end
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && rd_frame && nbits >= 16 && nbits < 48)
      spi_miso = resp[(nbits - 16) / 8][7 - (nbits % 8)];
    else
      spi_miso = 1'b0;
  end

  // ---------------- per-clock reference comparisons ----------------
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (!busy) chk(spi_cs_n && spi_sck && !spi_mosi, "R1 idle lines", {spi_cs_n, spi_sck, spi_mosi}, 32'h6);
      if (spi_cs_n) chk(spi_sck, "R2 sck high while deselected", 32'(spi_sck), 1);
      chk(req_ready == !busy, "R12 ready vs busy", 32'(req_ready), 32'(!busy));
      if (done) chk(busy, "R12 busy through done", 32'(busy), 1);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- expected frames ----------------
  logic [7:0] exp_bytes[$];
  int         exp_lens[$];

  task automatic exp_cfg(input bit wr, input logic [31:0] a, input logic [2:0] len, input logic [31:0] wd);
    logic [31:0] sd;
    logic [7:0]  cb;
    sd = wd;
    for (int k = 0; k < 4 - int'(len); k++) sd = sd << 8;   // R4 left-justify
    cb = {4'b0, 3'(4 - int'(len)), !wr};                     // R3/R5 config byte
    exp_bytes.push_back(C_WR); exp_bytes.push_back(A_CFG); exp_bytes.push_back(cb);
    for (int k = 3; k >= 0; k--) exp_bytes.push_back(a[8*k +: 8]);
    if (wr) for (int k = 3; k >= 0; k--) exp_bytes.push_back(sd[8*k +: 8]);
    exp_lens.push_back(wr ? 11 : 7);
  endtask

  task automatic exp_poll(input int n);
    for (int k = 0; k < n; k++) begin
      exp_bytes.push_back(C_RD); exp_bytes.push_back(A_ST); exp_bytes.push_back(8'h00);
      exp_lens.push_back(3);
    end
  endtask

  task automatic exp_fetch();
    exp_bytes.push_back(C_RD); exp_bytes.push_back(A_D0);
    for (int k = 0; k < 4; k++) exp_bytes.push_back(8'h00);
    exp_lens.push_back(6);
  endtask

  task automatic cmp_frames(input string tag);
    chk(cap_lens.size() == exp_lens.size(), {tag, " frame count"}, cap_lens.size(), exp_lens.size());
    for (int k = 0; k < exp_lens.size() && k < cap_lens.size(); k++)
      chk(cap_lens[k] == exp_lens[k], {tag, " frame length"}, cap_lens[k], exp_lens[k]);
    chk(cap_bytes.size() == exp_bytes.size(), {tag, " byte count"}, cap_bytes.size(), exp_bytes.size());
    for (int k = 0; k < exp_bytes.size() && k < cap_bytes.size(); k++)
      chk(cap_bytes[k] == exp_bytes[k], {tag, " frame byte"}, cap_bytes[k], exp_bytes[k]);
    cap_bytes.delete(); cap_lens.delete(); exp_bytes.delete(); exp_lens.delete();
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [2:0] len,
                        input logic [31:0] wd, output bit err, output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R12 busy after accept", 32'(busy), 1);
    lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    err = error; rd = rdata;
    @(negedge clk);
    chk(!done, "R12 done single pulse", 32'(done), 0);
  endtask

  initial begin
    bit e;
    logic [31:0] r;
    int lat;
    int cf;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && spi_sck && !spi_mosi, "R1 reset lines", {spi_cs_n, spi_sck, spi_mosi}, 32'h6);
    chk(!busy && req_ready && !done, "R12 reset handshake", {busy, req_ready, done}, 32'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R6: full write, one busy reply then complete
    status_q = '{8'h10, 8'h00};
    access(1'b1, 32'h12345678, 3'd4, 32'hA1B2C3D4, e, r, lat);
    chk(!e, "R6 write completes", 32'(e), 0);
    exp_cfg(1'b1, 32'h12345678, 3'd4, 32'hA1B2C3D4); exp_poll(2);
    cmp_frames("R3 write4");

    // R4: two-byte write is left-justified
    status_q = '{8'h00};
    access(1'b1, 32'h0000ABCD, 3'd2, 32'h0000BEEF, e, r, lat);
    chk(!e, "R4 write2 ok", 32'(e), 0);
    exp_cfg(1'b1, 32'h0000ABCD, 3'd2, 32'h0000BEEF); exp_poll(1);
    cmp_frames("R4 write2");

    // R5 R9: four-byte read
    status_q = '{8'h10, 8'h10, 8'h00};
    dev_word = 32'h89ABCDEF;
    access(1'b0, 32'hCAFE0004, 3'd4, 32'h0, e, r, lat);
    chk(!e, "R9 read ok", 32'(e), 0);
    chk(r == 32'h89ABCDEF, "R9 rdata assembly", r, 32'h89ABCDEF);
    exp_cfg(1'b0, 32'hCAFE0004, 3'd4, 32'h0); exp_poll(3); exp_fetch();
    cmp_frames("R5 read4");

    // R5 R9 R11: one-byte read, alternating data bits
    status_q = '{8'h00};
    dev_word = 32'h5A3C0FF1;
    access(1'b0, 32'h80000001, 3'd1, 32'h0, e, r, lat);
    chk(r == 32'h5A3C0FF1, "R9 rdata second pattern", r, 32'h5A3C0FF1);
    exp_cfg(1'b0, 32'h80000001, 3'd1, 32'h0); exp_poll(1); exp_fetch();
    cmp_frames("R5 read1");

    // R7: fail bit on second poll of a read, no fetch
    status_q = '{8'h10, 8'h18};
    dev_word = 32'hFFFFFFFF;
    access(1'b0, 32'h00000040, 3'd4, 32'h0, e, r, lat);
    chk(e, "R7 fail sets error", 32'(e), 1);
    chk(r == 32'h0, "R7 no data on failure", r, 0);
    exp_cfg(1'b0, 32'h00000040, 3'd4, 32'h0); exp_poll(2);
    cmp_frames("R7 fail");

    // R8: device stays busy, retry limit ends the write
    status_q.delete();
    status_default = 8'h10;
    access(1'b1, 32'h00000100, 3'd3, 32'h00123456, e, r, lat);
    chk(e, "R8 retry limit error", 32'(e), 1);
    exp_cfg(1'b1, 32'h00000100, 3'd3, 32'h00123456); exp_poll(RMAX);
    cmp_frames("R8 retry");
    status_default = 8'h00;

    // R10: oversize lengths rejected with no serial activity
    cf = cs_falls;
    access(1'b1, 32'h1, 3'd5, 32'h1, e, r, lat);
    chk(e, "R10 length 5 error", 32'(e), 1);
    chk(lat == 1, "R10 immediate done", lat, 1);
    access(1'b0, 32'h2, 3'd7, 32'h0, e, r, lat);
    chk(e && lat == 1, "R10 length 7 rejected", {e, 31'(lat)}, {1'b1, 31'd1});
    chk(cs_falls == cf, "R10 no chip select", cs_falls, cf);
    cmp_frames("R10 reject");

    // R12: error clears on next good access
    status_q = '{8'h00};
    access(1'b1, 32'hFFFFFFFF, 3'd1, 32'h000000C3, e, r, lat);
    chk(!e, "R12 error cleared", 32'(e), 0);
    exp_cfg(1'b1, 32'hFFFFFFFF, 3'd1, 32'h000000C3); exp_poll(1);
    cmp_frames("R2 write1");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule